// File: doc/BRIEF.md
# Masked BAR Window Decoder

This block is a bank of six 64-bit control registers that define three address windows: two memory-mapped I/O windows, each set by a base register and a mask register, and one register window whose size is fixed at 4 KiB. A single enable register switches each window on or off. Software reaches the bank through a simple register port. Each request carries a byte offset, a size and a write flag. The register index is the offset with its three low bits dropped, and only full 8-byte requests are carried out.

For every window the block drives three outputs: a decoded base (the stored base shifted right by 14), a decoded size, and a hit flag for the system address presented on its input. An MMIO window's size is the inverted mask shifted right by 14, plus one. A request the block cannot serve produces a one-cycle error pulse. So does rewriting a base or mask that is live, although that write is still stored. Any write to the enable register produces a one-cycle map-update pulse, which tells the logic downstream to re-read the windows. After reset the bases and masks hold defaults derived from two static identity inputs: the chip number and the unit number.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset, the enable register reads 0. MMIO window 0 base reads (0x3D00000000000 + 0x4000000000·chip + 0x1000000000·unit) << 14 and its mask reads 0x3FFF000000000 << 14. MMIO window 1 base reads (0x3FF8000000000 + 0x0200000000·chip + 0x0080000000·unit) << 14 and its mask reads 0x3FFFF80000000 << 14. The register-window base reads (0x3FFFE40000000 + 0x400000·chip + 0x100000·unit) << 14.
- R2: The register index is req_off_i >> 3, and offset bits 2:0 are ignored. The indices are: 0 window-0 base, 1 window-0 mask, 2 window-1 base, 3 window-1 mask, 4 register-window base, 5 enable. A request whose req_size_i is not 8 is dropped: it changes no register, returns no read data and raises err_o.
- R3: A write to either MMIO base or either MMIO mask stores only bits 63:30 of the data. All other bits become 0.
- R4: A write to the register-window base stores only bits 63:26 of the data.
- R5: A write to the enable register stores only bits 63:59. Bit 63 enables MMIO window 0, bit 62 enables MMIO window 1 and bit 61 enables the register window.
- R6: win_base_o[i] equals the window's stored base >> 14. win_size_o[i] equals (~mask >> 14) + 1 for windows 0 and 1, and 0x1000 for window 2.
- R7: win_hit_o[i] is 1 exactly when window i is enabled and win_base_o[i] <= sys_addr_i < win_base_o[i] + win_size_o[i]. It follows sys_addr_i combinationally.
- R8: A write to an MMIO base or mask is still stored while enable bit 63 or bit 62 is set, but err_o pulses for one cycle. The same holds for a write to the register-window base while enable bit 61 is set.
- R9: A write to an index above 5 changes no register and pulses err_o for one cycle.
- R10: A read returns the register contents on rd_data_o, with rd_valid_o high for one cycle, in the cycle after the request. Indices above 5 read as 0 and raise no error.
- R11: Every accepted write to the enable register pulses map_upd_o for one cycle, in the cycle after the request. No other access pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id_i | input | CHIP_W | Static chip number, used for the reset defaults |
| unit_id_i | input | UNIT_W | Static unit number, used for the reset defaults |
| req_valid_i | input | 1 | Register request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | OFF_W | Byte offset of the register |
| req_size_i | input | 4 | Access size in bytes; only 8 is served |
| req_wdata_i | input | 64 | Write data |
| rd_valid_o | output | 1 | Read data valid (one cycle) |
| rd_data_o | output | 64 | Read data |
| err_o | output | 1 | Error pulse for a rejected or flagged access |
| map_upd_o | output | 1 | Pulse after an enable-register write |
| sys_addr_i | input | 64 | System address to decode |
| win_base_o | output | 3x64 | Decoded base per window (0, 1 MMIO; 2 register window) |
| win_size_o | output | 3x64 | Decoded size per window |
| win_hit_o | output | 3 | Address hit per window |

## Verification
The properties assume that the request inputs are stable, defined values at every clock edge after reset, and that req_valid_i is low while reset is held. They also assume that the identity inputs never change. The bench drives every request on the falling edge and holds it for exactly one cycle, with req_valid_i low at time zero. It ties chip and unit to constants, so each output pulse can be traced back to a single request.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int REG_W = 64;
    localparam int DEC_SHIFT = 14;

    // Register indices (byte offset >> 3)
    localparam int IX_W0_BASE = 0;
    localparam int IX_W0_MASK = 1;
    localparam int IX_W1_BASE = 2;
    localparam int IX_W1_MASK = 3;
    localparam int IX_RW_BASE = 4;
    localparam int IX_ENABLE  = 5;

    // Enable bit positions
    localparam int EN_W0 = 63;
    localparam int EN_W1 = 62;
    localparam int EN_RW = 61;

    // Bits retained on write
    localparam logic [REG_W-1:0] KEEP_MMIO = 64'hFFFF_FFFF_C000_0000;
    localparam logic [REG_W-1:0] KEEP_RWIN = 64'hFFFF_FFFF_FC00_0000;
    localparam logic [REG_W-1:0] KEEP_EN   = 64'hF800_0000_0000_0000;

    localparam logic [REG_W-1:0] RWIN_SIZE = 64'h1000;

    typedef struct packed {
        logic [REG_W-1:0] w0_base;
        logic [REG_W-1:0] w0_mask;
        logic [REG_W-1:0] w1_base;
        logic [REG_W-1:0] w1_mask;
        logic [REG_W-1:0] rw_base;
        logic [REG_W-1:0] enable;
    } bank_t;

    typedef struct packed {
        bank_t            bank;
        logic             rd_valid;
        logic [REG_W-1:0] rd_data;
        logic             err;
        logic             map_upd;
    } state_t;

endpackage

// File: rtl/bwd_regbank.sv
module bwd_regbank
    import bwd_pkg::*;
#(
    parameter int OFF_W  = 9,
    parameter int CHIP_W = 3,
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHIP_W-1:0] chip_id_i,
    input  logic [UNIT_W-1:0] unit_id_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [OFF_W-1:0]  req_off_i,
    input  logic [3:0]        req_size_i,
    input  logic [REG_W-1:0]  req_wdata_i,
    output bank_t             bank_o,
    output logic              rd_valid_o,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              err_o,
    output logic              map_upd_o
);

    localparam int IDX_W = OFF_W - 3;
    localparam logic [IDX_W-1:0] IW0B = IDX_W'(IX_W0_BASE);
    localparam logic [IDX_W-1:0] IW0M = IDX_W'(IX_W0_MASK);
    localparam logic [IDX_W-1:0] IW1B = IDX_W'(IX_W1_BASE);
    localparam logic [IDX_W-1:0] IW1M = IDX_W'(IX_W1_MASK);
    localparam logic [IDX_W-1:0] IRWB = IDX_W'(IX_RW_BASE);
    localparam logic [IDX_W-1:0] IENA = IDX_W'(IX_ENABLE);

    state_t st_d, st_q;
    state_t st_rst;
    logic [IDX_W-1:0] idx;
    logic             mmio_live;
    logic [REG_W-1:0] chip_w, unit_w;
    logic             unused_off_lsb;

    assign idx            = req_off_i[OFF_W-1:3];
    assign unused_off_lsb = ^req_off_i[2:0];
    assign chip_w         = REG_W'(chip_id_i);
    assign unit_w         = REG_W'(unit_id_i);

    // Reset defaults from the identity inputs
    always_comb begin
        st_rst              = '0;
        st_rst.bank.w0_base = (64'h3D00000000000 + 64'h4000000000 * chip_w
                               + 64'h1000000000 * unit_w) << DEC_SHIFT;
        st_rst.bank.w0_mask = 64'h3FFF000000000 << DEC_SHIFT;
        st_rst.bank.w1_base = (64'h3FF8000000000 + 64'h0200000000 * chip_w
                               + 64'h0080000000 * unit_w) << DEC_SHIFT;
        st_rst.bank.w1_mask = 64'h3FFFF80000000 << DEC_SHIFT;
        st_rst.bank.rw_base = (64'h3FFFE40000000 + 64'h0000400000 * chip_w
                               + 64'h0000100000 * unit_w) << DEC_SHIFT;
        st_rst.bank.enable  = '0;
    end

    // Next-state computation
    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.err      = 1'b0;
        st_d.map_upd  = 1'b0;
        mmio_live     = st_q.bank.enable[EN_W0] | st_q.bank.enable[EN_W1];
        if (req_valid_i) begin
            if (req_size_i != 4'd8) begin
                st_d.err = 1'b1;
            end else if (req_write_i) begin
                case (idx)
                    IW0B: begin
                        st_d.bank.w0_base = req_wdata_i & KEEP_MMIO;
                        st_d.err          = mmio_live;
                    end
                    IW0M: begin
                        st_d.bank.w0_mask = req_wdata_i & KEEP_MMIO;
                        st_d.err          = mmio_live;
                    end
                    IW1B: begin
                        st_d.bank.w1_base = req_wdata_i & KEEP_MMIO;
                        st_d.err          = mmio_live;
                    end
                    IW1M: begin
                        st_d.bank.w1_mask = req_wdata_i & KEEP_MMIO;
                        st_d.err          = mmio_live;
                    end
                    IRWB: begin
                        st_d.bank.rw_base = req_wdata_i & KEEP_RWIN;
                        st_d.err          = st_q.bank.enable[EN_RW];
                    end
                    IENA: begin
                        st_d.bank.enable = req_wdata_i & KEEP_EN;
                        st_d.map_upd     = 1'b1;
                    end
                    default: st_d.err = 1'b1;
                endcase
            end else begin
                st_d.rd_valid = 1'b1;
                case (idx)
                    IW0B:    st_d.rd_data = st_q.bank.w0_base;
                    IW0M:    st_d.rd_data = st_q.bank.w0_mask;
                    IW1B:    st_d.rd_data = st_q.bank.w1_base;
                    IW1M:    st_d.rd_data = st_q.bank.w1_mask;
                    IRWB:    st_d.rd_data = st_q.bank.rw_base;
                    IENA:    st_d.rd_data = st_q.bank.enable;
                    default: st_d.rd_data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o     = st_q.bank;
    assign rd_valid_o = st_q.rd_valid;
    assign rd_data_o  = st_q.rd_data;
    assign err_o      = st_q.err;
    assign map_upd_o  = st_q.map_upd;

endmodule

// File: rtl/bwd_window.sv
module bwd_window
    import bwd_pkg::*;
#(
    parameter int               SHIFT      = 14,
    parameter bit               FIXED      = 1'b0,
    parameter logic [REG_W-1:0] FIXED_SIZE = 64'h1000
) (
    input  logic [REG_W-1:0] base_reg_i,
    input  logic [REG_W-1:0] mask_reg_i,
    input  logic             enable_i,
    input  logic [REG_W-1:0] addr_i,
    output logic [REG_W-1:0] base_o,
    output logic [REG_W-1:0] size_o,
    output logic             hit_o
);

    logic [REG_W:0] limit;

    assign base_o = base_reg_i >> SHIFT;

    generate
        if (FIXED) begin : g_fixed
            logic unused_mask;
            assign unused_mask = ^mask_reg_i;
            assign size_o      = FIXED_SIZE;
        end else begin : g_masked
            assign size_o = ((~mask_reg_i) >> SHIFT) + 64'd1;
        end
    endgenerate

    assign limit = {1'b0, base_o} + {1'b0, size_o};
    assign hit_o = enable_i && (addr_i >= base_o) && ({1'b0, addr_i} < limit);

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bwd_pkg::*;
#(
    parameter int OFF_W  = 9,
    parameter int CHIP_W = 3,
    parameter int UNIT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHIP_W-1:0]     chip_id_i,
    input  logic [UNIT_W-1:0]     unit_id_i,
    input  logic                  req_valid_i,
    input  logic                  req_write_i,
    input  logic [OFF_W-1:0]      req_off_i,
    input  logic [3:0]            req_size_i,
    input  logic [63:0]           req_wdata_i,
    output logic                  rd_valid_o,
    output logic [63:0]           rd_data_o,
    output logic                  err_o,
    output logic                  map_upd_o,
    input  logic [63:0]           sys_addr_i,
    output logic [2:0][63:0]      win_base_o,
    output logic [2:0][63:0]      win_size_o,
    output logic [2:0]            win_hit_o
);

    localparam int N_WIN = 3;

    bank_t                        bank;
    logic [N_WIN-1:0][REG_W-1:0]  base_vec;
    logic [N_WIN-1:0][REG_W-1:0]  mask_vec;
    logic [N_WIN-1:0]             en_vec;
    logic [REG_W-1:0]             en_q;

    bwd_regbank #(
        .OFF_W  (OFF_W),
        .CHIP_W (CHIP_W),
        .UNIT_W (UNIT_W)
    ) regbank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_id_i   (chip_id_i),
        .unit_id_i   (unit_id_i),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_off_i   (req_off_i),
        .req_size_i  (req_size_i),
        .req_wdata_i (req_wdata_i),
        .bank_o      (bank),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .err_o       (err_o),
        .map_upd_o   (map_upd_o)
    );

    assign en_q = bank.enable;

    always_comb begin
        base_vec[0] = bank.w0_base;
        base_vec[1] = bank.w1_base;
        base_vec[2] = bank.rw_base;
        mask_vec[0] = bank.w0_mask;
        mask_vec[1] = bank.w1_mask;
        mask_vec[2] = '0;
        en_vec[0]   = bank.enable[EN_W0];
        en_vec[1]   = bank.enable[EN_W1];
        en_vec[2]   = bank.enable[EN_RW];
    end

    generate
        for (genvar i = 0; i < N_WIN; i++) begin : g_win
            bwd_window #(
                .SHIFT      (DEC_SHIFT),
                .FIXED      (i == N_WIN - 1),
                .FIXED_SIZE (RWIN_SIZE)
            ) win_i (
                .base_reg_i (base_vec[i]),
                .mask_reg_i (mask_vec[i]),
                .enable_i   (en_vec[i]),
                .addr_i     (sys_addr_i),
                .base_o     (win_base_o[i]),
                .size_o     (win_size_o[i]),
                .hit_o      (win_hit_o[i])
            );
        end
    endgenerate

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
    parameter int OFF_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_write_i,
    input logic [OFF_W-1:0] req_off_i,
    input logic [3:0]       req_size_i,
    input logic             rd_valid_o,
    input logic             err_o,
    input logic             map_upd_o,
    input logic [2:0][63:0] win_base_o,
    input logic [2:0]       win_hit_o,
    input logic [63:0]      en_q
);

    p_rd_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(req_valid_i && !req_write_i && req_size_i == 4'd8));

    p_map_after_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        map_upd_o |-> $past(req_valid_i && req_write_i && req_size_i == 4'd8
                            && req_off_i[OFF_W-1:3] == (OFF_W-3)'(5)));

    p_err_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid_i));

    p_bad_size_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i != 4'd8) |=> err_o);

    p_hit0_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit_o[0] |-> en_q[63]);

    p_hit1_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit_o[1] |-> en_q[62]);

    p_hit2_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit_o[2] |-> en_q[61]);

    p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> $stable(win_base_o));

    p_enable_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[58:0] == '0);

endmodule

bind bar_window_decoder bwd_checker #(.OFF_W(OFF_W)) checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_off_i   (req_off_i),
    .req_size_i  (req_size_i),
    .rd_valid_o  (rd_valid_o),
    .err_o       (err_o),
    .map_upd_o   (map_upd_o),
    .win_base_o  (win_base_o),
    .win_hit_o   (win_hit_o),
    .en_q        (en_q)
);

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;

    localparam int OFF_W  = 9;
    localparam int CHIP_W = 3;
    localparam int UNIT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CHIP_W-1:0] chip_id = 3'd2;
    logic [UNIT_W-1:0] unit_id = 3'd1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [3:0]        req_size = 4'd8;
    logic [63:0]       req_wdata = '0;
    logic              rd_valid, err, map_upd;
    logic [63:0]       rd_data;
    logic [63:0]       sys_addr = '0;
    logic [2:0][63:0]  win_base, win_size;
    logic [2:0]        win_hit;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] m [0:5];

    always #4 clk = ~clk;

    bar_window_decoder #(.OFF_W(OFF_W), .CHIP_W(CHIP_W), .UNIT_W(UNIT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_id_i(chip_id), .unit_id_i(unit_id),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_off_i(req_off),
        .req_size_i(req_size), .req_wdata_i(req_wdata),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .err_o(err), .map_upd_o(map_upd),
        .sys_addr_i(sys_addr), .win_base_o(win_base), .win_size_o(win_size),
        .win_hit_o(win_hit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_base(input int w);
        return m[w == 0 ? 0 : (w == 1 ? 2 : 4)] >> 14;
    endfunction

    function automatic logic [63:0] exp_size(input int w);
        if (w == 2) return 64'h1000;
        return ((~m[w == 0 ? 1 : 3]) >> 14) + 64'd1;
    endfunction

    function automatic logic exp_en(input int w);
        return m[5][63 - w];
    endfunction

    task automatic issue(input logic wr, input int off, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_off = OFF_W'(off);
        req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr_reg(input int idx, input logic [63:0] d, input int lsb);
        logic e_err;
        logic [63:0] keep;
        e_err = 1'b0;
        keep = 64'hFFFF_FFFF_C000_0000;
        if (idx <= 3) e_err = m[5][63] | m[5][62];
        else if (idx == 4) begin e_err = m[5][61]; keep = 64'hFFFF_FFFF_FC00_0000; end
        else if (idx == 5) keep = 64'hF800_0000_0000_0000;
        else e_err = 1'b1;
        issue(1'b1, idx * 8 + lsb, 4'd8, d);
        chk(idx > 5 ? "R9 err on unknown write" : "R8 err on live rewrite", 64'(err), 64'(e_err));
        chk("R11 map pulse", 64'(map_upd), 64'(idx == 5));
        if (idx <= 5) m[idx] = d & keep;
    endtask

    task automatic rd_reg(input int idx);
        issue(1'b0, idx * 8, 4'd8, 64'h0);
        chk("R10 rd_valid", 64'(rd_valid), 64'd1);
        chk(idx == 4 ? "R4 readback" : (idx == 5 ? "R5 readback" : "R3 readback"),
            rd_data, idx <= 5 ? m[idx] : 64'h0);
        chk("R10 no err on read", 64'(err), 64'd0);
    endtask

    task automatic check_windows(input logic [63:0] a);
        sys_addr = a;
        #1;
        for (int w = 0; w < 3; w++) begin
            logic e;
            e = exp_en(w) && a >= exp_base(w) && a < exp_base(w) + exp_size(w);
            chk("R7 hit", 64'(win_hit[w]), 64'(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] pats [0:3];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'hAAAA_AAAA_AAAA_AAAA;
        pats[2] = 64'h5555_5555_5555_5555;
        pats[3] = 64'h0123_4567_89AB_CDEF;

        // R1 expected defaults, chip 2, unit 1
        m[0] = (64'h3D00000000000 + 64'h4000000000 * 2 + 64'h1000000000) << 14;
        m[1] = 64'h3FFF000000000 << 14;
        m[2] = (64'h3FF8000000000 + 64'h0200000000 * 2 + 64'h0080000000) << 14;
        m[3] = 64'h3FFFF80000000 << 14;
        m[4] = (64'h3FFFE40000000 + 64'h400000 * 2 + 64'h100000) << 14;
        m[5] = 64'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 err after reset", 64'(err), 64'd0);
        chk("R1 map after reset", 64'(map_upd), 64'd0);
        chk("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        for (int w = 0; w < 3; w++) begin
            chk("R6 reset base", win_base[w], exp_base(w));
            chk("R6 reset size", win_size[w], exp_size(w));
        end
        for (int i = 0; i < 6; i++) begin
            issue(1'b0, i * 8, 4'd8, 64'h0);
            chk("R1 reset value", rd_data, m[i]);
        end
        check_windows(m[0] >> 14);

        // R3 R4 R5 R9 R10: pattern sweep over all indices
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 16; i++) wr_reg(i, pats[p], 0);
            for (int i = 0; i < 16; i++) rd_reg(i);
        end

        // R2: offset low bits ignored; bad sizes dropped
        wr_reg(5, 64'h0, 0);
        wr_reg(1, 64'h1234_5678_FFFF_FFFF, 5);
        rd_reg(1);
        for (int s = 0; s < 16; s++) begin
            if (s != 8) begin
                issue(1'b1, 0, 4'(s), 64'hDEAD_BEEF_0000_0000);
                chk("R2 bad size err", 64'(err), 64'd1);
                issue(1'b0, 0, 4'(s), 64'h0);
                chk("R2 bad size err", 64'(err), 64'd1);
                chk("R2 bad size no rd_valid", 64'(rd_valid), 64'd0);
            end
        end
        rd_reg(0);

        // R6 R7: small windows, swept under every enable combination
        wr_reg(0, 64'h0000_0000_4000_0000, 0);
        wr_reg(1, 64'hFFFF_FFFF_C000_0000, 0);
        wr_reg(2, 64'h0000_0001_0000_0000, 0);
        wr_reg(3, 64'hFFFF_FFFF_0000_0000, 0);
        wr_reg(4, 64'h0000_0000_0C00_0000, 0);
        for (int e = 0; e < 8; e++) begin
            wr_reg(5, {3'(e), 61'h0}, 0);
            for (int w = 0; w < 3; w++) begin
                chk("R6 base", win_base[w], exp_base(w));
                chk("R6 size", win_size[w], exp_size(w));
            end
            for (int a = 0; a < 32'h90000; a += (e == 7 ? 32'h400 : 32'h1000))
                check_windows(64'(a));
            for (int w = 0; w < 3; w++) begin
                check_windows(exp_base(w) - 64'd1);
                check_windows(exp_base(w));
                check_windows(exp_base(w) + exp_size(w) - 64'd1);
                check_windows(exp_base(w) + exp_size(w));
            end
        end

        // R8: live rewrites are stored and flagged
        wr_reg(5, 64'h2000_0000_0000_0000, 0);
        wr_reg(0, 64'h0000_0000_8000_0000, 0);
        wr_reg(4, 64'h0000_0000_1000_0000, 0);
        rd_reg(4);
        wr_reg(5, 64'h8000_0000_0000_0000, 0);
        wr_reg(3, 64'hFFFF_FFFF_8000_0000, 0);
        wr_reg(4, 64'h0000_0000_0400_0000, 0);
        rd_reg(3);
        rd_reg(4);
        for (int w = 0; w < 3; w++) chk("R6 base after rewrite", win_base[w], exp_base(w));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule